// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

This block is a single-port synchronous SRAM of 36-bit words, split into four 9-bit byte lanes, with every control and data input captured on the rising clock and read data returned through an output register. A read therefore produces its word one clock after the command edge. A separate burst counter outside the block supplies the current word address each cycle. The core decodes three chip selects, a global write that overrides the byte-write path, and per-lane write selects.

Outputs are not bidirectional. The block presents a data word and a valid flag, and the valid flag stands in for the tri-state driver. Valid is gated at once by an active-low output enable and by the sleep input. It is also suppressed for the first read that follows a deselected cycle, so that banks sharing a bus do not collide. While sleep is high, commands are ignored and the stored contents are kept.

Top module: `pipe_burst_sram`

## Requirements
- R1: After reset, `rdValid` is 0 until a read has been completed.
- R2: A read command registered at clock edge k loads the addressed word into the output register at edge k+1. `rdData` then carries that word, and `rdValid` is 1 when output enable is low, sleep is low and the cycle is not masked.
- R3: A cycle is selected only when `sel1N` is 0, `sel2` is 1 and `sel3N` is 0. Any other combination is a deselected cycle that neither writes nor reads.
- R4: When `wrAllN` is 0 in a selected cycle, all four lanes are written, whatever `byteWrEnN` and `laneSelN` are.
- R5: When `wrAllN` is 1 and `byteWrEnN` is 0, lane i (bits 9i+8 down to 9i of the word) is written only if `laneSelN[i]` is 0. The other lanes keep their contents.
- R6: A selected cycle with no lane enabled is a read. This covers `byteWrEnN`=1, and also `byteWrEnN`=0 with all `laneSelN` bits at 1. A write cycle never raises `rdValid`.
- R7: While `outEnN` is 1, `rdValid` is 0 in the same cycle, with no clock edge needed.
- R8: The first read after a deselected cycle, a sleep cycle or reset delivers its word with `rdValid` at 0. A read that directly follows a selected cycle is not masked.
- R9: While `sleep` is 1, `rdValid` is 0 and commands registered in that cycle have no effect on memory. Stored data survives.
- R10: A write registered at edge k is stored at edge k+1. A read of the same address registered at edge k+1 returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Current word address from the burst counter |
| sel1N | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3N | input | 1 | Chip select, active low |
| wrAllN | input | 1 | Global write, all lanes, active low |
| byteWrEnN | input | 1 | Enables per-lane writes, active low |
| laneSelN | input | LANES | Per-lane write selects, active low |
| wrData | input | LANES*LANE_W | Write data |
| outEnN | input | 1 | Output enable, active low, acts at once |
| sleep | input | 1 | Sleep request, active high |
| rdData | output | LANES*LANE_W | Output register contents |
| rdValid | output | 1 | High when `rdData` would be driven onto the bus |

## Verification
A command applied before edge k is registered at k and takes effect at k+1. Its read word and its valid flag can therefore be seen from the falling edge after k+1, two falling edges after the command was driven. The gating by output enable and sleep acts within the same cycle. The bench keeps a two-deep history of the commands it has driven. At each falling edge it retires the oldest command into a behavioural memory model and compares that result with the outputs. Each comparison uses the output-enable and sleep values on the wires at that moment.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  // Strobes from the control side to the datapath for the registered cycle
  typedef struct packed {
    logic rdEn;    // selected cycle with no lane write: load output register
    logic wrEn;    // at least one lane is written this cycle
    logic showOk;  // previous registered cycle was selected, read may drive
  } sramStrobe_t;

endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel1N,
  input  logic              sel2,
  input  logic              sel3N,
  input  logic              wrAllN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneSelN,
  input  logic              sleep,
  output sramStrobe_t       stb,
  output logic [LANES-1:0]  laneWr,
  output logic [ADDR_W-1:0] addrQ
);

  logic             selQ;
  logic             sleepQ;
  logic             wrAllQ;
  logic             byteEnQ;
  logic [LANES-1:0] laneQ;
  logic             prevDesel;
  logic             opSel;
  logic [LANES-1:0] laneDec;

  // Input capture registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= 1'b0;
      sleepQ  <= 1'b0;
      wrAllQ  <= 1'b0;
      byteEnQ <= 1'b0;
      laneQ   <= '0;
    end else begin
      selQ    <= ~sel1N & sel2 & ~sel3N;
      sleepQ  <= sleep;
      wrAllQ  <= ~wrAllN;
      byteEnQ <= ~byteWrEnN;
      laneQ   <= ~laneSelN;
    end
  end

  always_ff @(posedge clk) begin
    addrQ <= addr;
  end

  // A sleeping cycle counts as not selected
  assign opSel = selQ & ~sleepQ;

  // Write decode: global write beats the byte path
  for (genvar i = 0; i < LANES; i++) begin : g_laneDec
    assign laneDec[i] = wrAllQ | (byteEnQ & laneQ[i]);
  end

  assign laneWr     = opSel ? laneDec : '0;
  assign stb.wrEn   = |laneWr;
  assign stb.rdEn   = opSel & ~(|laneDec);
  assign stb.showOk = ~prevDesel;

  // Remembers whether the registered cycle just executed was deselected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevDesel <= 1'b1;
    else       prevDesel <= ~opSel;
  end

endmodule

// File: rtl/pipe_sram_dpath.sv
module pipe_sram_dpath
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobe_t       stb,
  input  logic [LANES-1:0]  laneWr,
  input  logic [ADDR_W-1:0] addrQ,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              outVld
);

  logic [WORD_W-1:0] wrDataQ;

  always_ff @(posedge clk) begin
    wrDataQ <= wrData;
  end

  // One storage bank and one output register per byte lane
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] outQ;

    always_ff @(posedge clk) begin
      if (laneWr[i]) bank[addrQ] <= wrDataQ[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (stb.rdEn) outQ <= bank[addrQ];
    end

    assign rdData[i*LANE_W +: LANE_W] = outQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outVld <= 1'b0;
    else       outVld <= stb.rdEn & stb.showOk;
  end

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel1N,
  input  logic                    sel2,
  input  logic                    sel3N,
  input  logic                    wrAllN,
  input  logic                    byteWrEnN,
  input  logic [LANES-1:0]        laneSelN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEnN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);

  sramStrobe_t       stb;
  logic [LANES-1:0]  laneWr;
  logic [ADDR_W-1:0] addrQ;
  logic              outVld;

  pipe_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr),
    .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N),
    .wrAllN(wrAllN), .byteWrEnN(byteWrEnN), .laneSelN(laneSelN),
    .sleep(sleep), .stb(stb), .laneWr(laneWr), .addrQ(addrQ)
  );

  pipe_sram_dpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .laneWr(laneWr), .addrQ(addrQ),
    .wrData(wrData), .rdData(rdData), .outVld(outVld)
  );

  // Output enable and sleep act on the driver without waiting for a clock
  assign rdValid = outVld & ~outEnN & ~sleep;

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sel1N,
  input logic             sel2,
  input logic             sel3N,
  input logic             wrAllN,
  input logic             byteWrEnN,
  input logic [LANES-1:0] laneSelN,
  input logic             outEnN,
  input logic             sleep,
  input logic             rdValid
);

  logic [1:0] warm;
  logic       cmdSel;
  logic       cmdWr;
  logic       cmdRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign cmdSel = ~sel1N & sel2 & ~sel3N & ~sleep;
  assign cmdWr  = cmdSel & (~wrAllN | (~byteWrEnN & ~(&laneSelN)));
  assign cmdRd  = cmdSel & ~cmdWr;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd0) |-> !rdValid);

  // R7
  oe_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !rdValid);

  // R9
  sleep_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !rdValid);

  // R8
  first_read_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && !$past(cmdSel, 3) && $past(cmdRd, 2)) |-> !rdValid);

  // R2
  read_shows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(cmdSel, 3) && $past(cmdRd, 2) && !outEnN && !sleep)
      |-> rdValid);

  // R6
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(cmdWr, 2)) |-> !rdValid);

endmodule

bind pipe_burst_sram pipe_sram_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/pipe_burst_sram_bench.sv
`timescale 1ns/1ps
module pipe_burst_sram_bench;

  localparam int ADDR_W = 10;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic              s1N, s2, s3N;
    logic              allN, benN;
    logic [LANES-1:0]  lnN;
    logic [WORD_W-1:0] d;
    logic              oeN, slp;
  } cmd_t;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] addr;
  logic              sel1N, sel2, sel3N, wrAllN, byteWrEnN, outEnN, sleep;
  logic [LANES-1:0]  laneSelN;
  logic [WORD_W-1:0] wrData, rdData;
  logic              rdValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [WORD_W-1:0] mMem [8];
  bit                mPrevDesel;
  bit                mVld;
  logic [WORD_W-1:0] mData;
  cmd_t              hist [$];

  always #2.5 clk = ~clk;

  pipe_burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe_burst_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N),
    .wrAllN(wrAllN), .byteWrEnN(byteWrEnN), .laneSelN(laneSelN), .wrData(wrData),
    .outEnN(outEnN), .sleep(sleep), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(bit ok, string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic cmd_t mkIdle();
    cmd_t c;
    c.a = '0; c.s1N = 1'b1; c.s2 = 1'b0; c.s3N = 1'b1;
    c.allN = 1'b1; c.benN = 1'b1; c.lnN = '1; c.d = '0;
    c.oeN = 1'b0; c.slp = 1'b0;
    return c;
  endfunction

  function automatic cmd_t mkRd(int a);
    cmd_t c = mkIdle();
    c.a = ADDR_W'(a); c.s1N = 1'b0; c.s2 = 1'b1; c.s3N = 1'b0;
    return c;
  endfunction

  function automatic cmd_t mkAll(int a, logic [WORD_W-1:0] d);
    cmd_t c = mkRd(a);
    c.allN = 1'b0; c.d = d;
    return c;
  endfunction

  function automatic cmd_t mkByte(int a, logic [LANES-1:0] lnN, logic [WORD_W-1:0] d);
    cmd_t c = mkRd(a);
    c.benN = 1'b0; c.lnN = lnN; c.d = d;
    return c;
  endfunction

  // Behavioural effect of one registered command
  task automatic modelExec(cmd_t c);
    bit sel;
    logic [LANES-1:0] lanes;
    sel = !c.s1N && c.s2 && !c.s3N && !c.slp;
    for (int i = 0; i < LANES; i++) lanes[i] = !c.allN || (!c.benN && !c.lnN[i]);
    mVld = 0;
    if (sel && lanes != '0) begin
      for (int i = 0; i < LANES; i++)
        if (lanes[i]) mMem[c.a[2:0]][i*LANE_W +: LANE_W] = c.d[i*LANE_W +: LANE_W];
    end else if (sel) begin
      mData = mMem[c.a[2:0]];
      mVld  = !mPrevDesel;
    end
    mPrevDesel = !sel;
  endtask

  task automatic drive(cmd_t c);
    addr = c.a; sel1N = c.s1N; sel2 = c.s2; sel3N = c.s3N;
    wrAllN = c.allN; byteWrEnN = c.benN; laneSelN = c.lnN; wrData = c.d;
    outEnN = c.oeN; sleep = c.slp;
  endtask

  // One clock: retire the command driven two cycles ago, compare, drive next
  task automatic step(cmd_t c, string req);
    bit expV;
    @(negedge clk);
    modelExec(hist.pop_front());
    expV = mVld && !outEnN && !sleep;
    check(rdValid === expV, {req, " valid"}, WORD_W'(rdValid), WORD_W'(expV));
    if (expV) check(rdData === mData, {req, " data"}, rdData, mData);
    hist.push_back(c);
    drive(c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cmd_t c;
    rstN = 1'b0;
    drive(mkIdle());
    mPrevDesel = 1; mVld = 0; mData = '0;
    for (int i = 0; i < 8; i++) mMem[i] = '0;
    hist.push_back(mkIdle());
    hist.push_back(mkIdle());
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(rdValid === 1'b0, "R1 reset", WORD_W'(rdValid), '0);

    // Preload addresses 0..7 with full-word writes
    for (int i = 0; i < 8; i++) step(mkAll(i, {4{9'(i * 37 + 5)}}), "R4");
    // R4: global write ignores byte path even with all lane selects high
    c = mkAll(5, 36'h1_2345_6789); c.benN = 1'b0; c.lnN = '1;
    step(c, "R4");
    // R10: read right after the write
    step(mkRd(5), "R10");
    step(mkRd(5), "R4");
    // R5: lanes 0 and 2 only
    step(mkByte(5, 4'b1010, 36'hA_BCDE_F012), "R5");
    step(mkRd(5), "R5");
    step(mkByte(3, 4'b0111, 36'hF_FFFF_FFFF), "R5");
    step(mkRd(3), "R5");
    // R6: byte enable with no lane selected is a read
    step(mkByte(5, 4'b1111, 36'h0_0000_0000), "R6");
    step(mkRd(5), "R6");
    step(mkRd(5), "R6");
    step(mkRd(5), "R6");
    // R3: each select off in turn blocks a write
    c = mkAll(6, 36'hD_EAD0_BEEF); c.s1N = 1'b1; step(c, "R3");
    c = mkAll(6, 36'hD_EAD0_BEEF); c.s2  = 1'b0; step(c, "R3");
    c = mkAll(6, 36'hD_EAD0_BEEF); c.s3N = 1'b1; step(c, "R3");
    step(mkRd(6), "R3");
    step(mkRd(6), "R3");
    step(mkRd(6), "R3");
    step(mkRd(6), "R3");
    // R8: first read after deselect is masked, next shows
    step(mkIdle(), "R8");
    step(mkRd(2), "R8");
    step(mkRd(4), "R8");
    step(mkRd(7), "R8");
    step(mkRd(1), "R8");
    step(mkRd(1), "R8");
    // R7: output enable high hides data in the same cycle
    c = mkRd(2); c.oeN = 1'b1; step(c, "R7");
    step(mkRd(2), "R7");
    c = mkRd(3); c.oeN = 1'b1; step(c, "R7");
    step(mkRd(3), "R7");
    step(mkRd(3), "R7");
    // R9: sleep blocks writes and output, data kept
    c = mkAll(4, 36'h5_5555_5555); c.slp = 1'b1; step(c, "R9");
    c = mkRd(4); c.slp = 1'b1; step(c, "R9");
    c = mkRd(4); c.slp = 1'b1; step(c, "R9");
    step(mkRd(4), "R9");
    step(mkRd(4), "R9");
    step(mkRd(4), "R9");
    step(mkRd(4), "R9");
    // R2: mixed traffic
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 10;
      int a = $urandom % 8;
      logic [WORD_W-1:0] d = {$urandom, $urandom}[WORD_W-1:0];
      if (r == 0) begin
        c = mkRd(a);
        case ($urandom % 3)
          0: c.s1N = 1'b1;
          1: c.s2  = 1'b0;
          default: c.s3N = 1'b1;
        endcase
      end else if (r == 1) c = mkAll(a, d);
      else if (r <= 3) c = mkByte(a, 4'($urandom), d);
      else c = mkRd(a);
      if ($urandom % 8 == 0) c.oeN = 1'b1;
      if ($urandom % 16 == 0) c.slp = 1'b1;
      step(c, "R2");
    end
    step(mkIdle(), "R2");
    step(mkIdle(), "R2");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule